// File: doc/BRIEF.md
# Generic Command Packet Queue

This block is the transmit path for generic commands in the host side of a serial display link controller. Software first loads the payload for a command into a payload FIFO as 32-bit words. It then writes a 24-bit header word into a command FIFO. The header write is what starts transmission. The block takes one header at a time and classifies it from its data type as a short or a long packet. It then sends the packet as a byte stream under a valid/ready handshake. A short packet is the header plus its error-correcting byte. A long packet is the header, the number of payload bytes given by the header, and a 16-bit checksum.

A second FIFO holds response words that the receive side returns for read requests. A sticky flag shows that a read response has completed. One status byte reports the emptiness of all three FIFOs and the read-complete flag. If a long packet needs payload that has not yet been queued, the block stops emitting. It raises an underflow indication until the missing word arrives.

Top module: `gen_cmd_queue`

## Requirements
- R1: Header word fields are data type in bits 5:0, virtual channel (0 to 3) in bits 7:6, field A in bits 15:8 and field B in bits 23:16. The first three bytes sent are bits 7:0, 15:8 and 23:16 of the header word, in that order.
- R2: The fourth byte sent holds a 6-bit Hamming code in bits 5:0, with bits 7:6 zero. Each header bit i that is set XORs a fixed 6-bit column into the code. The columns for bits 0..23 are 07,0B,0D,0E,13,15,16,19,1A,1C,23,25,26,29,2A,2C,31,32,34,38,1F,2F,37,3B (hex).
- R3: When data type bit 3 is clear, the packet is short. Exactly four bytes are sent, and out_last is high only on the fourth.
- R4: When data type bit 3 is set, the packet is long. The word count is {field B, field A}, with field A as the low byte. That many payload bytes follow the header. They are taken little-endian from the payload words, byte 0 from bits 7:0. The unused upper bytes of the final word are discarded.
- R5: A long packet ends with a CRC-16 over its payload: polynomial x^16+x^12+x^5+1, LSB-first, seed FFFF. The low byte is sent first and out_last is high on the high byte. A word count of zero sends FFFF as the CRC.
- R6: Packets leave in header order. Each long packet uses payload words in the order they were queued.
- R7: A header with data type 09 (null) or 19 (blanking) is removed from the command FIFO and sends nothing. It also leaves the payload FIFO untouched.
- R8: If the payload FIFO is empty while payload bytes are still owed, out_valid is low and underflow is high. Transmission resumes when a word arrives.
- R9: While out_valid is high and out_ready is low, out_data and out_last stay unchanged and out_valid stays high.
- R10: status bit 1 is high when the response FIFO is empty. Bit 3 is high when the payload FIFO is empty. Bit 5 is high when the command FIFO is empty. All other bits except bit 7 are zero.
- R11: status bit 7 (read done) is zero after reset and is set by a rsp_done pulse. It is cleared when a read-request header (type 04, 14, 24 or 06) is taken from the command FIFO.
- R12: Response words come out on rsp_rd_data in push order. rsp_rd_en advances to the next word.
- R13: After the handshake on a byte with out_last high, out_valid is low for the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pld_wr_en | input | 1 | Push payload word |
| pld_wr_data | input | 32 | Payload word, byte 0 in bits 7:0 |
| hdr_wr_en | input | 1 | Push header word (starts a packet) |
| hdr_wr_data | input | 24 | Header: type, channel, field A, field B |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of a packet |
| out_ready | input | 1 | Sink accepts the byte |
| underflow | output | 1 | Stalled waiting for payload |
| rsp_wr_en | input | 1 | Push response word from receive side |
| rsp_wr_data | input | 32 | Response word |
| rsp_rd_en | input | 1 | Pop response word |
| rsp_rd_data | output | 32 | Head of the response FIFO |
| rsp_done | input | 1 | Pulse: read response complete |
| status | output | 8 | FIFO empty flags and read-done flag |

## Verification
A corrupted byte index or state shows as a wrong or missing byte within one handshake. The scoreboard compares every byte and every out_last against a stream built from the requirements, so such an error appears at once. A mis-tracked payload pointer shows up in the next long packet, which then carries the wrong payload and a wrong CRC. A wrong drop or underflow decision shows at the ports within a few cycles, as unexpected bytes or as a missing stall.

// File: rtl/gcq_pkg.sv
package gcq_pkg;

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_PLD, S_CRC} tx_state_e;

  function automatic logic [5:0] ecc_column(input int unsigned bit_idx);
    logic [5:0] c;
    case (bit_idx)
      0: c = 6'h07;  1: c = 6'h0B;  2: c = 6'h0D;  3: c = 6'h0E;
      4: c = 6'h13;  5: c = 6'h15;  6: c = 6'h16;  7: c = 6'h19;
      8: c = 6'h1A;  9: c = 6'h1C; 10: c = 6'h23; 11: c = 6'h25;
      12: c = 6'h26; 13: c = 6'h29; 14: c = 6'h2A; 15: c = 6'h2C;
      16: c = 6'h31; 17: c = 6'h32; 18: c = 6'h34; 19: c = 6'h38;
      20: c = 6'h1F; 21: c = 6'h2F; 22: c = 6'h37; default: c = 6'h3B;
    endcase
    return c;
  endfunction

  function automatic logic [5:0] hdr_ecc(input logic [23:0] h);
    logic [5:0] acc;
    acc = '0;
    for (int unsigned i = 0; i < 24; i++) begin
      if (h[i]) acc = acc ^ ecc_column(i);
    end
    return acc;
  endfunction

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {8'h00, b};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    end
    return r;
  endfunction

  function automatic logic type_is_dropped(input logic [5:0] dt);
    return (dt == 6'h09) || (dt == 6'h19);
  endfunction

  function automatic logic type_is_read(input logic [5:0] dt);
    return (dt == 6'h04) || (dt == 6'h14) || (dt == 6'h24) || (dt == 6'h06);
  endfunction

endpackage

// File: rtl/gcq_fifo.sv
module gcq_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [AW:0]   FULL_CNT = (AW+1)'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [AW:0]   cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign do_push = push && (cnt_q != FULL_CNT);
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_push) wr_d = (wr_q == LAST) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_d = (rd_q == LAST) ? '0 : rd_q + 1'b1;
    if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
    else if (!do_push && do_pop) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din;
  end

  // R6
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/gcq_tx.sv
module gcq_tx
  import gcq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_empty,
  input  logic [23:0] cmd_word,
  output logic        cmd_pop,
  input  logic        pld_empty,
  input  logic [31:0] pld_word,
  output logic        pld_pop,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic        out_last,
  input  logic        out_ready,
  output logic        underflow,
  output logic        rd_req
);
  tx_state_e   state_q, state_d;
  logic [23:0] hdr_q, hdr_d;
  logic [15:0] idx_q, idx_d;
  logic [15:0] crc_q, crc_d;
  logic [15:0] wc;
  logic        is_long;
  logic [1:0]  lane;
  logic        last_pld;

  assign wc       = {hdr_q[23:16], hdr_q[15:8]};
  assign is_long  = hdr_q[3];
  assign lane     = idx_q[1:0];
  assign last_pld = (idx_q == wc - 16'd1);

  always_comb begin
    state_d   = state_q;
    hdr_d     = hdr_q;
    idx_d     = idx_q;
    crc_d     = crc_q;
    cmd_pop   = 1'b0;
    pld_pop   = 1'b0;
    out_valid = 1'b0;
    out_data  = 8'h00;
    out_last  = 1'b0;
    underflow = 1'b0;
    rd_req    = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (!cmd_empty) begin
          cmd_pop = 1'b1;
          if (!type_is_dropped(cmd_word[5:0])) begin
            hdr_d   = cmd_word;
            idx_d   = '0;
            crc_d   = 16'hFFFF;
            state_d = S_HDR;
            rd_req  = type_is_read(cmd_word[5:0]);
          end
        end
      end
      S_HDR: begin
        out_valid = 1'b1;
        case (lane)
          2'd0:    out_data = hdr_q[7:0];
          2'd1:    out_data = hdr_q[15:8];
          2'd2:    out_data = hdr_q[23:16];
          default: out_data = {2'b00, hdr_ecc(hdr_q)};
        endcase
        out_last = (lane == 2'd3) && !is_long;
        if (out_ready) begin
          if (lane == 2'd3) begin
            idx_d = '0;
            if (!is_long)        state_d = S_IDLE;
            else if (wc == '0)   state_d = S_CRC;
            else                 state_d = S_PLD;
          end else begin
            idx_d = idx_q + 16'd1;
          end
        end
      end
      S_PLD: begin
        if (pld_empty) begin
          underflow = 1'b1;
        end else begin
          out_valid = 1'b1;
          out_data  = pld_word[{lane, 3'b000} +: 8];
          if (out_ready) begin
            crc_d   = crc_step(crc_q, out_data);
            pld_pop = (lane == 2'd3) || last_pld;
            if (last_pld) begin
              idx_d   = '0;
              state_d = S_CRC;
            end else begin
              idx_d = idx_q + 16'd1;
            end
          end
        end
      end
      default: begin
        out_valid = 1'b1;
        out_data  = idx_q[0] ? crc_q[15:8] : crc_q[7:0];
        out_last  = idx_q[0];
        if (out_ready) begin
          if (idx_q[0]) begin
            idx_d   = '0;
            state_d = S_IDLE;
          end else begin
            idx_d = idx_q + 16'd1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      hdr_q   <= '0;
      idx_q   <= '0;
      crc_q   <= '0;
    end else begin
      state_q <= state_d;
      hdr_q   <= hdr_d;
      idx_q   <= idx_d;
      crc_q   <= crc_d;
    end
  end

  // R8
  stall_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> !out_valid);

  // R9
  hold_under_backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R13
  gap_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> !out_valid);

endmodule

// File: rtl/gen_cmd_queue.sv
module gen_cmd_queue #(
  parameter int PLD_DEPTH = 16,
  parameter int CMD_DEPTH = 4,
  parameter int RSP_DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pld_wr_en,
  input  logic [31:0] pld_wr_data,
  input  logic        hdr_wr_en,
  input  logic [23:0] hdr_wr_data,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic        out_last,
  input  logic        out_ready,
  output logic        underflow,
  input  logic        rsp_wr_en,
  input  logic [31:0] rsp_wr_data,
  input  logic        rsp_rd_en,
  output logic [31:0] rsp_rd_data,
  input  logic        rsp_done,
  output logic [7:0]  status
);
  logic        cmd_empty, cmd_pop, pld_empty, pld_pop, rsp_empty, rd_req;
  logic [23:0] cmd_word;
  logic [31:0] pld_word;
  logic        rd_done_q, rd_done_d;

  gcq_fifo #(.WIDTH(32), .DEPTH(PLD_DEPTH)) pld_fifo_i (
    .clk(clk), .rst_n(rst_n), .push(pld_wr_en), .din(pld_wr_data),
    .pop(pld_pop), .dout(pld_word), .empty(pld_empty));

  gcq_fifo #(.WIDTH(24), .DEPTH(CMD_DEPTH)) cmd_fifo_i (
    .clk(clk), .rst_n(rst_n), .push(hdr_wr_en), .din(hdr_wr_data),
    .pop(cmd_pop), .dout(cmd_word), .empty(cmd_empty));

  gcq_fifo #(.WIDTH(32), .DEPTH(RSP_DEPTH)) rsp_fifo_i (
    .clk(clk), .rst_n(rst_n), .push(rsp_wr_en), .din(rsp_wr_data),
    .pop(rsp_rd_en), .dout(rsp_rd_data), .empty(rsp_empty));

  gcq_tx tx_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_empty(cmd_empty), .cmd_word(cmd_word), .cmd_pop(cmd_pop),
    .pld_empty(pld_empty), .pld_word(pld_word), .pld_pop(pld_pop),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .out_ready(out_ready), .underflow(underflow), .rd_req(rd_req));

  always_comb begin
    rd_done_d = rd_done_q;
    if (rd_req)        rd_done_d = 1'b0;
    else if (rsp_done) rd_done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_done_q <= 1'b0;
    else        rd_done_q <= rd_done_d;
  end

  assign status = {rd_done_q, 1'b0, cmd_empty, 1'b0, pld_empty, 1'b0, rsp_empty, 1'b0};

  // R11
  rd_done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && !rd_req) |=> status[7]);

endmodule

// File: tb/gen_cmd_queue_tb_top.sv
module gen_cmd_queue_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pld_wr_en = 1'b0;
  logic [31:0] pld_wr_data = '0;
  logic        hdr_wr_en = 1'b0;
  logic [23:0] hdr_wr_data = '0;
  logic        out_valid, out_last, underflow;
  logic [7:0]  out_data;
  logic        out_ready = 1'b1;
  logic        rsp_wr_en = 1'b0;
  logic [31:0] rsp_wr_data = '0;
  logic        rsp_rd_en = 1'b0;
  logic [31:0] rsp_rd_data;
  logic        rsp_done = 1'b0;
  logic [7:0]  status;

  int n_checks = 0;
  int n_fail   = 0;
  bit slow_ready = 1'b0;
  int cyc = 0;

  logic [8:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] pbuf [64];

  localparam logic [5:0] COL [24] = '{6'h07,6'h0B,6'h0D,6'h0E,6'h13,6'h15,6'h16,6'h19,
    6'h1A,6'h1C,6'h23,6'h25,6'h26,6'h29,6'h2A,6'h2C,6'h31,6'h32,6'h34,6'h38,
    6'h1F,6'h2F,6'h37,6'h3B};

  gen_cmd_queue dut_i (
    .clk(clk), .rst_n(rst_n), .pld_wr_en(pld_wr_en), .pld_wr_data(pld_wr_data),
    .hdr_wr_en(hdr_wr_en), .hdr_wr_data(hdr_wr_data), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last), .out_ready(out_ready),
    .underflow(underflow), .rsp_wr_en(rsp_wr_en), .rsp_wr_data(rsp_wr_data),
    .rsp_rd_en(rsp_rd_en), .rsp_rd_data(rsp_rd_data), .rsp_done(rsp_done),
    .status(status));

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] ref_ecc(input logic [23:0] h);
    logic [5:0] e = '0;
    for (int i = 0; i < 24; i++) if (h[i]) e ^= COL[i];
    return e;
  endfunction

  function automatic logic [15:0] ref_crc(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int k = 0; k < n; k++) begin
      for (int i = 0; i < 8; i++) begin
        logic fb;
        fb = c[0] ^ pbuf[k][i];
        c = c >> 1;
        if (fb) c ^= 16'h8408;
      end
    end
    return c;
  endfunction

  task automatic exp_push(input logic [7:0] d, input logic l, input string tag);
    exp_q.push_back({l, d});
    tag_q.push_back(tag);
  endtask

  task automatic exp_header(input logic [23:0] h, input logic is_last);
    exp_push(h[7:0], 1'b0, "R1");
    exp_push(h[15:8], 1'b0, "R1");
    exp_push(h[23:16], 1'b0, "R1");
    exp_push({2'b00, ref_ecc(h)}, is_last, is_last ? "R3" : "R2");
  endtask

  task automatic push_pld(input logic [31:0] w);
    @(posedge clk); #1 pld_wr_en = 1'b1; pld_wr_data = w;
    @(posedge clk); #1 pld_wr_en = 1'b0;
  endtask

  task automatic push_hdr(input logic [23:0] h);
    @(posedge clk); #1 hdr_wr_en = 1'b1; hdr_wr_data = h;
    @(posedge clk); #1 hdr_wr_en = 1'b0;
  endtask

  function automatic logic [31:0] pack_word(input int w, input int n);
    logic [31:0] r;
    for (int k = 0; k < 4; k++)
      r[8*k +: 8] = (4*w + k < n) ? pbuf[4*w + k] : 8'hEE;
    return r;
  endfunction

  task automatic exp_long(input logic [23:0] h, input int n);
    logic [15:0] c;
    exp_header(h, 1'b0);
    for (int k = 0; k < n; k++) exp_push(pbuf[k], 1'b0, "R4");
    c = ref_crc(n);
    exp_push(c[7:0], 1'b0, "R5");
    exp_push(c[15:8], 1'b1, "R5");
  endtask

  task automatic send_long(input logic [5:0] dt, input logic [1:0] vc, input int n);
    logic [23:0] h;
    h = {n[7:0] ^ 8'h00, n[7:0], vc, dt};
    h[23:16] = n[15:8];
    for (int w = 0; w < (n + 3) / 4; w++) push_pld(pack_word(w, n));
    exp_long(h, n);
    push_hdr(h);
  endtask

  task automatic send_short(input logic [5:0] dt, input logic [1:0] vc, input logic [7:0] a, input logic [7:0] b);
    logic [23:0] h;
    h = {b, a, vc, dt};
    exp_header(h, 1'b1);
    push_hdr(h);
  endtask

  task automatic drain();
    for (int i = 0; i < 2000 && exp_q.size() != 0; i++) @(posedge clk);
    repeat (4) @(posedge clk);
    check(exp_q.size() == 0, "R6", exp_q.size(), 0);
  endtask

  // ready driver
  initial begin
    forever begin
      @(posedge clk); #1;
      cyc++;
      out_ready = slow_ready ? ((cyc % 3) != 1) : 1'b1;
    end
  end

  // scoreboard monitor
  logic       prev_stall = 1'b0;
  logic [8:0] prev_byte  = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        // R9 held byte under backpressure
        check(out_valid && ({out_last, out_data} == prev_byte), "R9",
              {out_valid, out_last, out_data}, {1'b1, prev_byte});
      end
      prev_stall = out_valid && !out_ready;
      prev_byte  = {out_last, out_data};
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6", {out_last, out_data}, 0);
        end else begin
          logic [8:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({out_last, out_data} == e, t, {out_last, out_data}, e);
        end
      end
    end
  end

  initial begin
    #(4 * 150000);
    check(1'b0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(status == 8'h2A, "R10", status, 8'h2A);
    check(!out_valid && !underflow, "R8", {out_valid, underflow}, 0);

    // R3 short packet, R1 channel 3
    send_short(6'h15, 2'd3, 8'hB0, 8'h07);
    drain();

    // R4 long packet with partial last word, R5 crc
    for (int k = 0; k < 5; k++) pbuf[k] = 8'h10 + 8'(k * 17);
    send_long(6'h39, 2'd1, 5);
    drain();

    // R4 exact word multiple under backpressure (R9)
    slow_ready = 1'b1;
    for (int k = 0; k < 12; k++) pbuf[k] = 8'(k * 29 + 3);
    send_long(6'h29, 2'd2, 12);
    drain();
    slow_ready = 1'b0;

    // R5 zero-length long packet
    send_long(6'h29, 2'd0, 0);
    drain();

    // R7 null and blanking dropped, payload untouched
    for (int k = 0; k < 3; k++) pbuf[k] = 8'hA1 + 8'(k);
    push_pld(pack_word(0, 3));
    push_hdr({8'h00, 8'h04, 2'd0, 6'h09});
    push_hdr({8'h00, 8'h02, 2'd0, 6'h19});
    repeat (8) @(posedge clk);
    @(negedge clk);
    check(!out_valid, "R7", out_valid, 0);
    check(status == 8'h22, "R7", status, 8'h22);
    exp_long({8'h00, 8'h03, 2'd0, 6'h39}, 3);
    push_hdr({8'h00, 8'h03, 2'd0, 6'h39});
    drain();

    // R6 back-to-back ordering
    for (int k = 0; k < 2; k++) pbuf[k] = 8'h5A + 8'(k);
    send_long(6'h39, 2'd1, 2);
    send_short(6'h05, 2'd0, 8'h11, 8'h00);
    drain();

    // R8 underflow stall
    for (int k = 0; k < 8; k++) pbuf[k] = 8'hC0 + 8'(k);
    push_pld(pack_word(0, 8));
    exp_long({8'h00, 8'h08, 2'd0, 6'h29}, 8);
    push_hdr({8'h00, 8'h08, 2'd0, 6'h29});
    repeat (20) @(posedge clk);
    @(negedge clk);
    check(underflow && !out_valid, "R8", {underflow, out_valid}, 2'b10);
    push_pld(pack_word(1, 8));
    drain();
    check(!underflow, "R8", underflow, 0);

    // R10 payload empty flag
    push_pld(32'h01020304);
    @(negedge clk);
    check(status == 8'h22, "R10", status, 8'h22);
    for (int k = 0; k < 4; k++) pbuf[k] = 8'h04 - 8'(k);
    exp_long({8'h00, 8'h04, 2'd0, 6'h39}, 4);
    push_hdr({8'h00, 8'h04, 2'd0, 6'h39});
    drain();
    check(status == 8'h2A, "R10", status, 8'h2A);

    // R11 read done flag
    @(posedge clk); #1 rsp_done = 1'b1;
    @(posedge clk); #1 rsp_done = 1'b0;
    @(negedge clk);
    check(status[7], "R11", status, 8'hAA);
    send_short(6'h14, 2'd0, 8'h0A, 8'h00);
    drain();
    check(!status[7], "R11", status, 8'h2A);
    @(posedge clk); #1 rsp_done = 1'b1;
    @(posedge clk); #1 rsp_done = 1'b0;
    @(negedge clk);
    check(status[7], "R11", status, 8'hAA);

    // R12 response FIFO order
    @(posedge clk); #1 rsp_wr_en = 1'b1; rsp_wr_data = 32'hDEAD0001;
    @(posedge clk); #1 rsp_wr_data = 32'hBEEF0002;
    @(posedge clk); #1 rsp_wr_en = 1'b0;
    @(negedge clk);
    check(!status[1], "R12", status, 8'hA8);
    check(rsp_rd_data == 32'hDEAD0001, "R12", rsp_rd_data, 32'hDEAD0001);
    @(posedge clk); #1 rsp_rd_en = 1'b1;
    @(posedge clk); #1 rsp_rd_en = 1'b0;
    @(negedge clk);
    check(rsp_rd_data == 32'hBEEF0002, "R12", rsp_rd_data, 32'hBEEF0002);
    @(posedge clk); #1 rsp_rd_en = 1'b1;
    @(posedge clk); #1 rsp_rd_en = 1'b0;
    @(negedge clk);
    check(status[1], "R10", status, 8'hAA);

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule